// File: doc/BRIEF.md
# Lazy Floating-Point Context Save Tracker

This block sits beside a processor's exception sequencer and FPU. It decides whether, and when, the floating-point registers must be written to the space reserved for them in an exception stack frame, and whether they must be read back on exception return. When deferral is enabled, the block does not write the registers at exception entry. It marks the save as pending, and the real write starts only when the handler issues its first floating-point instruction. That instruction is held off with a stall until the memory engine acknowledges the save.

The block keeps a small stack of per-frame records: whether the frame reserved floating-point space, whether that space was filled, the frame base address and the save size. With these records, a return either restores the registers, quietly drops a save that never happened, or leaves the floating-point state inactive. When a secure context that requests extended protection is interrupted, the save covers the full register file. The registers are then wiped before the handler may use them, so no secure value can leak.

Top module: `fp_lazy_ctx`

## Requirements
- R1: After reset, save_req_o, restore_req_o, fp_clear_o, stall_o, fp_active_o and lazy_pend_o are all 0.
- R2: An FP instruction (fp_op_i) taken while no save is pending and no transfer is outstanding sets fp_active_o on the next cycle, with stall_o low.
- R3: On an exception entry with fp_active_o high and lazy_en_i high, lazy_pend_o goes to 1 and fp_active_o to 0 on the next cycle, and no request is issued.
- R4: On an exception entry with fp_active_o high and lazy_en_i low, save_req_o rises on the next cycle with xfer_addr_o equal to frame_addr_i, and fp_active_o drops to 0.
- R5: An fp_op_i while lazy_pend_o is high drives stall_o high in the same cycle and raises save_req_o on the next cycle, with the pending frame address. After the acknowledge, lazy_pend_o is 0, fp_active_o is 1 and stall_o is low.
- R6: xfer_words_o is 34 when the interrupted context was secure (ctx_secure_i=1) and extended protection was requested (ext_save_i=1) at entry; otherwise it is 18.
- R7: fp_clear_o pulses for exactly one cycle, the cycle after a 34-word save is acknowledged, and never after an 18-word save.
- R8: A return to a frame whose save is still pending clears lazy_pend_o, sets fp_active_o and issues no request.
- R9: A return to a frame whose FP space was filled raises restore_req_o with that frame's address and word count. After the acknowledge, fp_active_o is 1.
- R10: A return to a frame that reserved no FP space leaves fp_active_o at 0 and issues no request.
- R11: An entry while a save is pending creates no second pending save, and the later save still targets the first frame's address.
- R12: An fp_op_i in the same cycle as an exception entry or return has no effect on fp_active_o or on the requests.
- R13: Only one request is high at a time, and it stays high with a stable address until xfer_ack_i.

Top module parameters: AW (address width), DEPTH (nesting levels tracked), WORDS_BASE, WORDS_EXT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| exc_entry_i | input | 1 | One-cycle exception entry event |
| exc_return_i | input | 1 | One-cycle exception return event |
| fp_op_i | input | 1 | FP instruction at issue; held while stall_o is high |
| lazy_en_i | input | 1 | Deferred save enable |
| ctx_secure_i | input | 1 | Interrupted context is secure (sampled at entry) |
| ext_save_i | input | 1 | Extended protection requested (sampled at entry) |
| frame_addr_i | input | AW | Base of FP area in the new frame (sampled at entry) |
| xfer_ack_i | input | 1 | Memory engine completion of the current request |
| save_req_o | output | 1 | Write FP registers to the frame |
| restore_req_o | output | 1 | Read FP registers from the frame |
| xfer_addr_o | output | AW | Base address of the current transfer |
| xfer_words_o | output | clog2(WORDS_EXT+1) | Word count of the current transfer |
| fp_clear_o | output | 1 | Zero all FP registers |
| stall_o | output | 1 | Hold the issuing FP instruction |
| fp_active_o | output | 1 | FP context active in the current context |
| lazy_pend_o | output | 1 | A deferred save is outstanding |

## Verification
The handler's first FP instruction can arrive in the same cycle as an exception entry or return. The bench provokes this by raising fp_op_i together with exc_entry_i, and later together with exc_return_i, while a live FP context exists. It judges the outcome from the pending and active flags and from the absence of any save request on the following cycles. A second overlap comes from holding fp_op_i across the acknowledge of a save. There the stall must drop in the cycle the save completes, and the wipe strobe must appear only for the full-file case.

// File: rtl/fp_lazy_pkg.sv
package fp_lazy_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAVE_LAZY,
    ST_SAVE_EAGER,
    ST_RESTORE
  } xfer_st_e;
endpackage

// File: rtl/fp_ctx_stack.sv
module fp_ctx_stack #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          push_fp_i,
  input  logic          push_saved_i,
  input  logic          push_big_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic          mark_i,
  input  logic [LW-1:0] mark_idx_i,
  output logic          top_fp_o,
  output logic          top_saved_o,
  output logic          top_big_o,
  output logic [AW-1:0] top_addr_o,
  output logic [LW-1:0] level_o
);
  logic [LW-1:0] ptr_q;
  logic [DEPTH-1:0] fp_q, saved_q, big_q;
  logic [AW-1:0] addr_q [DEPTH];

  wire full  = (ptr_q == LW'(DEPTH));
  wire empty = (ptr_q == '0);
  wire do_push = push_i && !full;
  wire do_pop  = pop_i && !empty && !push_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (do_push) ptr_q <= ptr_q + 1'b1;
    else if (do_pop) ptr_q <= ptr_q - 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fp_q[g]    <= 1'b0;
        saved_q[g] <= 1'b0;
        big_q[g]   <= 1'b0;
        addr_q[g]  <= '0;
      end else if (do_push && ptr_q == LW'(g)) begin
        fp_q[g]    <= push_fp_i;
        saved_q[g] <= push_saved_i;
        big_q[g]   <= push_big_i;
        addr_q[g]  <= push_addr_i;
      end else if (mark_i && mark_idx_i == LW'(g)) begin
        saved_q[g] <= 1'b1;
      end
    end
  end

  always_comb begin
    top_fp_o    = 1'b0;
    top_saved_o = 1'b0;
    top_big_o   = 1'b0;
    top_addr_o  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ptr_q == LW'(i + 1)) begin
        top_fp_o    = fp_q[i];
        top_saved_o = saved_q[i];
        top_big_o   = big_q[i];
        top_addr_o  = addr_q[i];
      end
    end
  end

  assign level_o = ptr_q;
endmodule

// File: rtl/fp_lazy_ctrl.sv
module fp_lazy_ctrl
  import fp_lazy_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LW         = 3,
  parameter int WORDS_BASE = 18,
  parameter int WORDS_EXT  = 34,
  localparam int WW        = $clog2(WORDS_EXT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          exc_entry_i,
  input  logic          exc_return_i,
  input  logic          fp_op_i,
  input  logic          lazy_en_i,
  input  logic          ctx_secure_i,
  input  logic          ext_save_i,
  input  logic [AW-1:0] frame_addr_i,
  input  logic          xfer_ack_i,
  input  logic          top_fp_i,
  input  logic          top_saved_i,
  input  logic          top_big_i,
  input  logic [AW-1:0] top_addr_i,
  input  logic [LW-1:0] level_i,
  output logic          push_o,
  output logic          pop_o,
  output logic          push_fp_o,
  output logic          push_saved_o,
  output logic          push_big_o,
  output logic [AW-1:0] push_addr_o,
  output logic          mark_o,
  output logic [LW-1:0] mark_idx_o,
  output logic          save_req_o,
  output logic          restore_req_o,
  output logic [AW-1:0] xfer_addr_o,
  output logic [WW-1:0] xfer_words_o,
  output logic          fp_clear_o,
  output logic          stall_o,
  output logic          fp_active_o,
  output logic          lazy_pend_o
);
  localparam logic [WW-1:0] W_BASE = WW'(WORDS_BASE);
  localparam logic [WW-1:0] W_EXT  = WW'(WORDS_EXT);

  xfer_st_e      st_q;
  logic          fp_active_q, lazy_pend_q, clear_q, xfer_big_q, lazy_big_q;
  logic [AW-1:0] xfer_addr_q, lazy_addr_q;
  logic [LW-1:0] lazy_lvl_q;

  wire idle    = (st_q == ST_IDLE);
  wire ent     = idle && exc_entry_i;
  wire ret     = idle && exc_return_i && !exc_entry_i;
  wire fp_use  = idle && fp_op_i && !exc_entry_i && !exc_return_i;
  wire big_now = ctx_secure_i && ext_save_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      fp_active_q <= 1'b0;
      lazy_pend_q <= 1'b0;
      clear_q     <= 1'b0;
      xfer_big_q  <= 1'b0;
      lazy_big_q  <= 1'b0;
      xfer_addr_q <= '0;
      lazy_addr_q <= '0;
      lazy_lvl_q  <= '0;
    end else begin
      clear_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (ent) begin
            if (fp_active_q) begin
              fp_active_q <= 1'b0;
              if (lazy_en_i) begin
                lazy_pend_q <= 1'b1;
                lazy_addr_q <= frame_addr_i;
                lazy_big_q  <= big_now;
                lazy_lvl_q  <= level_i;
              end else begin
                st_q        <= ST_SAVE_EAGER;
                xfer_addr_q <= frame_addr_i;
                xfer_big_q  <= big_now;
              end
            end
          end else if (ret) begin
            if (!top_fp_i) begin
              fp_active_q <= 1'b0;
            end else if (top_saved_i) begin
              st_q        <= ST_RESTORE;
              xfer_addr_q <= top_addr_i;
              xfer_big_q  <= top_big_i;
            end else begin
              // save never happened: context still live in registers
              lazy_pend_q <= 1'b0;
              fp_active_q <= 1'b1;
            end
          end else if (fp_use) begin
            if (lazy_pend_q) begin
              st_q        <= ST_SAVE_LAZY;
              xfer_addr_q <= lazy_addr_q;
              xfer_big_q  <= lazy_big_q;
            end else begin
              fp_active_q <= 1'b1;
            end
          end
        end
        ST_SAVE_LAZY: begin
          if (xfer_ack_i) begin
            st_q        <= ST_IDLE;
            lazy_pend_q <= 1'b0;
            fp_active_q <= 1'b1;
            clear_q     <= xfer_big_q;
          end
        end
        ST_SAVE_EAGER: begin
          if (xfer_ack_i) begin
            st_q    <= ST_IDLE;
            clear_q <= xfer_big_q;
          end
        end
        ST_RESTORE: begin
          if (xfer_ack_i) begin
            st_q        <= ST_IDLE;
            fp_active_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign push_o       = ent;
  assign pop_o        = ret;
  assign push_fp_o    = fp_active_q;
  assign push_saved_o = fp_active_q && !lazy_en_i;
  assign push_big_o   = big_now;
  assign push_addr_o  = frame_addr_i;
  assign mark_o       = (st_q == ST_SAVE_LAZY) && xfer_ack_i;
  assign mark_idx_o   = lazy_lvl_q;

  assign save_req_o    = (st_q == ST_SAVE_LAZY) || (st_q == ST_SAVE_EAGER);
  assign restore_req_o = (st_q == ST_RESTORE);
  assign xfer_addr_o   = xfer_addr_q;
  assign xfer_words_o  = xfer_big_q ? W_EXT : W_BASE;
  assign fp_clear_o    = clear_q;
  assign stall_o       = fp_op_i && (lazy_pend_q || !idle);
  assign fp_active_o   = fp_active_q;
  assign lazy_pend_o   = lazy_pend_q;
endmodule

// File: rtl/fp_lazy_ctx.sv
module fp_lazy_ctx #(
  parameter int AW         = 32,
  parameter int DEPTH      = 4,
  parameter int WORDS_BASE = 18,
  parameter int WORDS_EXT  = 34,
  localparam int WW        = $clog2(WORDS_EXT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          exc_entry_i,
  input  logic          exc_return_i,
  input  logic          fp_op_i,
  input  logic          lazy_en_i,
  input  logic          ctx_secure_i,
  input  logic          ext_save_i,
  input  logic [AW-1:0] frame_addr_i,
  input  logic          xfer_ack_i,
  output logic          save_req_o,
  output logic          restore_req_o,
  output logic [AW-1:0] xfer_addr_o,
  output logic [WW-1:0] xfer_words_o,
  output logic          fp_clear_o,
  output logic          stall_o,
  output logic          fp_active_o,
  output logic          lazy_pend_o
);
  localparam int LW = $clog2(DEPTH + 1);

  logic          push, pop, push_fp, push_saved, push_big, mark;
  logic [AW-1:0] push_addr, top_addr;
  logic [LW-1:0] mark_idx, level;
  logic          top_fp, top_saved, top_big;

  fp_ctx_stack #(.DEPTH(DEPTH), .AW(AW)) i_stack (
    .clk_i, .rst_ni,
    .push_i(push), .pop_i(pop),
    .push_fp_i(push_fp), .push_saved_i(push_saved), .push_big_i(push_big),
    .push_addr_i(push_addr),
    .mark_i(mark), .mark_idx_i(mark_idx),
    .top_fp_o(top_fp), .top_saved_o(top_saved), .top_big_o(top_big),
    .top_addr_o(top_addr), .level_o(level)
  );

  fp_lazy_ctrl #(
    .AW(AW), .LW(LW), .WORDS_BASE(WORDS_BASE), .WORDS_EXT(WORDS_EXT)
  ) i_ctrl (
    .clk_i, .rst_ni,
    .exc_entry_i, .exc_return_i, .fp_op_i, .lazy_en_i,
    .ctx_secure_i, .ext_save_i, .frame_addr_i, .xfer_ack_i,
    .top_fp_i(top_fp), .top_saved_i(top_saved), .top_big_i(top_big),
    .top_addr_i(top_addr), .level_i(level),
    .push_o(push), .pop_o(pop), .push_fp_o(push_fp), .push_saved_o(push_saved),
    .push_big_o(push_big), .push_addr_o(push_addr),
    .mark_o(mark), .mark_idx_o(mark_idx),
    .save_req_o, .restore_req_o, .xfer_addr_o, .xfer_words_o,
    .fp_clear_o, .stall_o, .fp_active_o, .lazy_pend_o
  );
endmodule

// File: rtl/fp_lazy_ctx_chk.sv
module fp_lazy_ctx_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fp_op_i,
  input logic          xfer_ack_i,
  input logic          save_req_o,
  input logic          restore_req_o,
  input logic [AW-1:0] xfer_addr_o,
  input logic          fp_clear_o,
  input logic          stall_o,
  input logic          fp_active_o,
  input logic          lazy_pend_o
);
  a_r13_one_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(save_req_o && restore_req_o));

  a_r13_save_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_req_o && !xfer_ack_i |=> save_req_o && $stable(xfer_addr_o));

  a_r13_rest_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_req_o && !xfer_ack_i |=> restore_req_o && $stable(xfer_addr_o));

  a_r7_clear_after_save: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fp_clear_o) |-> $past(save_req_o && xfer_ack_i));

  a_r7_clear_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_clear_o |=> !fp_clear_o);

  a_r5_stall_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_op_i && lazy_pend_o |-> stall_o);

  a_r3_not_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fp_active_o && lazy_pend_o));

  a_r8_pend_exit_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lazy_pend_o) |-> fp_active_o);
endmodule

bind fp_lazy_ctx fp_lazy_ctx_chk #(.AW(AW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fp_op_i(fp_op_i), .xfer_ack_i(xfer_ack_i),
  .save_req_o(save_req_o), .restore_req_o(restore_req_o),
  .xfer_addr_o(xfer_addr_o), .fp_clear_o(fp_clear_o), .stall_o(stall_o),
  .fp_active_o(fp_active_o), .lazy_pend_o(lazy_pend_o)
);

// File: tb/test_fp_lazy_ctx.sv
module test_fp_lazy_ctx;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int WW = 6;

  logic clk = 0, rst_ni = 0;
  logic exc_entry = 0, exc_return = 0, fp_op = 0, lazy_en = 1;
  logic ctx_secure = 0, ext_save = 0, xfer_ack = 0;
  logic [AW-1:0] frame_addr = '0;
  logic save_req, restore_req, fp_clear, stall, fp_active, lazy_pend;
  logic [AW-1:0] xfer_addr;
  logic [WW-1:0] xfer_words;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fp_lazy_ctx #(.AW(AW)) i_fp_lazy_ctx (
    .clk_i(clk), .rst_ni, .exc_entry_i(exc_entry), .exc_return_i(exc_return),
    .fp_op_i(fp_op), .lazy_en_i(lazy_en), .ctx_secure_i(ctx_secure),
    .ext_save_i(ext_save), .frame_addr_i(frame_addr), .xfer_ack_i(xfer_ack),
    .save_req_o(save_req), .restore_req_o(restore_req), .xfer_addr_o(xfer_addr),
    .xfer_words_o(xfer_words), .fp_clear_o(fp_clear), .stall_o(stall),
    .fp_active_o(fp_active), .lazy_pend_o(lazy_pend)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic enter(input logic [AW-1:0] a, input logic sec, input logic ext);
    frame_addr = a; ctx_secure = sec; ext_save = ext; exc_entry = 1;
    cyc();
    exc_entry = 0; ctx_secure = 0; ext_save = 0;
  endtask

  task automatic leave();
    exc_return = 1;
    cyc();
    exc_return = 0;
  endtask

  task automatic ack();
    xfer_ack = 1;
    cyc();
    xfer_ack = 0;
  endtask

  task automatic use_fp_plain();
    fp_op = 1;
    #1 chk("R2 no stall", stall, 0);
    cyc();
    fp_op = 0;
    chk("R2 fp_active set", fp_active, 1);
  endtask

  task automatic t_reset();
    chk("R1 save_req", save_req, 0);
    chk("R1 restore_req", restore_req, 0);
    chk("R1 clear", fp_clear, 0);
    chk("R1 stall", stall, 0);
    chk("R1 fp_active", fp_active, 0);
    chk("R1 lazy_pend", lazy_pend, 0);
  endtask

  task automatic t_no_fp_frame();
    enter(32'h1000, 0, 0);
    chk("R10 entry no pend", lazy_pend, 0);
    chk("R10 entry no save", save_req, 0);
    leave();
    chk("R10 return no restore", restore_req, 0);
    chk("R10 return fp_active", fp_active, 0);
  endtask

  task automatic t_lazy_unused();
    use_fp_plain();
    enter(32'h2000, 1, 1);
    chk("R3 lazy_pend", lazy_pend, 1);
    chk("R3 fp_active", fp_active, 0);
    chk("R3 no save", save_req, 0);
    cyc(); cyc();
    chk("R3 still no save", save_req, 0);
    leave();
    chk("R8 pend cleared", lazy_pend, 0);
    chk("R8 fp_active back", fp_active, 1);
    chk("R8 no restore", restore_req, 0);
    cyc();
    chk("R8 no request later", save_req | restore_req, 0);
  endtask

  task automatic t_lazy_used(input logic sec, input logic ext,
                             input logic [AW-1:0] a, input int words, input logic clr);
    enter(a, sec, ext);
    chk("R3 pend on entry", lazy_pend, 1);
    fp_op = 1;
    #1 chk("R5 stall now", stall, 1);
    cyc();
    chk("R5 save_req", save_req, 1);
    chk("R5 save addr", xfer_addr, a);
    chk("R6 save words", xfer_words, words);
    cyc(); cyc();
    chk("R13 save held", save_req, 1);
    chk("R13 addr stable", xfer_addr, a);
    chk("R5 still stalled", stall, 1);
    ack();
    chk("R5 pend cleared", lazy_pend, 0);
    chk("R5 fp_active", fp_active, 1);
    chk("R5 stall released", stall, 0);
    chk("R7 clear strobe", fp_clear, clr);
    chk("R13 save dropped", save_req, 0);
    fp_op = 0;
    cyc();
    chk("R7 clear one cycle", fp_clear, 0);
    leave();
    chk("R9 restore_req", restore_req, 1);
    chk("R13 single request", save_req, 0);
    chk("R9 restore addr", xfer_addr, a);
    chk("R9 restore words", xfer_words, words);
    ack();
    chk("R9 restore done", restore_req, 0);
    chk("R9 fp_active", fp_active, 1);
  endtask

  task automatic t_eager(input logic sec, input logic ext, input int words, input logic clr);
    lazy_en = 0;
    enter(32'h5000, sec, ext);
    chk("R4 save_req now", save_req, 1);
    chk("R4 save addr", xfer_addr, 32'h5000);
    chk("R6 eager words", xfer_words, words);
    chk("R4 fp_active off", fp_active, 0);
    chk("R4 no pend", lazy_pend, 0);
    ack();
    chk("R7 eager clear", fp_clear, clr);
    chk("R4 save done", save_req, 0);
    lazy_en = 1;
    cyc();
    leave();
    chk("R9 eager restore", restore_req, 1);
    chk("R9 eager restore addr", xfer_addr, 32'h5000);
    ack();
    chk("R9 eager fp_active", fp_active, 1);
  endtask

  task automatic t_nested();
    enter(32'h3000, 0, 0);
    enter(32'h3800, 1, 1);
    chk("R11 one pend", lazy_pend, 1);
    chk("R11 no save", save_req, 0);
    fp_op = 1;
    cyc();
    chk("R11 save addr outer", xfer_addr, 32'h3000);
    chk("R11 words outer", xfer_words, 18);
    ack();
    fp_op = 0;
    chk("R7 no clear base", fp_clear, 0);
    leave();
    chk("R10 inner return no req", save_req | restore_req, 0);
    chk("R10 inner return fp_active", fp_active, 0);
    leave();
    chk("R9 outer restore", restore_req, 1);
    chk("R9 outer addr", xfer_addr, 32'h3000);
    ack();
    chk("R9 outer fp_active", fp_active, 1);
  endtask

  task automatic t_overlap();
    frame_addr = 32'h6000; exc_entry = 1; fp_op = 1;
    cyc();
    exc_entry = 0; fp_op = 0;
    chk("R12 entry pend", lazy_pend, 1);
    chk("R12 entry fp_active", fp_active, 0);
    cyc();
    chk("R12 entry no save", save_req, 0);
    exc_return = 1; fp_op = 1;
    cyc();
    exc_return = 0; fp_op = 0;
    chk("R12 return pend", lazy_pend, 0);
    chk("R12 return fp_active", fp_active, 1);
    cyc();
    chk("R12 return no req", save_req | restore_req, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    t_reset();
    rst_ni = 1;
    cyc();
    t_reset();
    t_no_fp_frame();
    t_lazy_unused();
    t_lazy_used(0, 0, 32'h4000, 18, 0);
    t_lazy_used(1, 1, 32'h4400, 34, 1);
    t_lazy_used(1, 0, 32'h4800, 18, 0);
    t_lazy_used(0, 1, 32'h4c00, 18, 0);
    t_eager(0, 0, 18, 0);
    t_eager(1, 1, 34, 1);
    t_nested();
    t_overlap();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule